// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the device side of a byte-wide NAND flash bus. The host drives chip enable and the two latch selects, and pulses a write strobe. On each rising edge of that strobe the block takes one byte as a command, an address or data. The block checks that multi-cycle sequences arrive in order, with the correct number of address cycles, before it starts an array operation. The sequences are page read, page program, column-relocated data input and output, internal copy between pages, and block erase.

A small behavioural array stands in for the flash cells, along with a one-page buffer and a fixed busy interval for each operation type. A ready/busy output is low while an operation runs. A status byte can be read at any time. While busy, the sequencer accepts only the status and reset commands.

Top module: `nand_cmd_seq`

## Requirements
- R1: A bus cycle is taken only on a rising edge of `we_n` while `ce_n` is low. `cle`=1/`ale`=0 selects a command, `ale`=1/`cle`=0 selects an address, and both low selects data. A strobe with `ce_n` high has no effect.
- R2: Page read is command 00h, then five address cycles (column low, column high, row bits 7:0, 15:8, 23:16), then 30h. After the busy interval, `dout` shows the page byte at the given column, and each rising edge of `re_n` (with `ce_n` low) advances the column by one.
- R3: If 30h arrives after only four address cycles, no read starts, `rb` stays high and the sequence is dropped.
- R4: Page program is 80h, five address cycles, one or more data bytes written from the given column upward, then 10h. After the busy interval the page holds the written bytes, and every byte that was not written reads FFh.
- R5: 10h that does not follow a program setup, its addresses and at least one data byte starts nothing: `rb` stays high and the array is unchanged.
- R6: During data entry, 85h followed by two column cycles moves the write column. This may be repeated any number of times, and a later byte overwrites an earlier one at the same column.
- R7: During data output, 05h followed by two column cycles and E0h moves the read column. This may be repeated.
- R8: Block erase is 60h, three row cycles (no column cycles), then D0h. It sets every byte of both pages in the block to FFh. A block is two pages, and row bit 0 selects the page within the block.
- R9: Copy-back is 00h, five source address cycles, then 35h. The source page is loaded into the buffer with no output. Then 85h, five destination address cycles, optional data bytes and 10h program the buffer (including any changed bytes) to the destination page.
- R10: `rb` is low from the cycle after a confirm command until the operation ends. While `rb` is low, commands other than 70h and FFh are ignored, and `ce_n` going high does not stop the operation.
- R11: After 70h, `dout` shows the status byte: bit 6 = ready, bit 0 = fail, all other bits 0. Fail is set when a program or erase row address has any bit at or above bit 3 set (outside the eight-page array). In that case the array is not changed.
- R12: FFh, accepted in any state, aborts a running or unconfirmed operation, returns to idle with `rb` high and clears the fail bit. An aborted program leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Write strobe; a byte is taken on its rising edge |
| re_n | input | 1 | Read strobe; rising edge advances the output column |
| din | input | 8 | Byte written by the host |
| dout | output | 8 | Page data or status byte |
| rb | output | 1 | Ready (1) / busy (0) |

## Verification
The end of an internal operation and a status read can land in the same cycle. The bench issues 70h while a program is running. It then samples `dout` on every cycle through completion and requires bit 6 to track `rb` exactly, including the cycle where busy ends. A reset command that lands on a running operation is also provoked. The bench judges it by `rb` rising at once and by reading back that the target page was left erased.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_ADR, S_RD_CONF, S_PG_ADR, S_PG_DATA, S_RIN_ADR,
        S_ER_ADR, S_ER_CONF, S_BUSY, S_RD_OUT, S_ROUT_ADR, S_ROUT_CONF,
        S_CB_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_READ, OP_CBREAD, OP_PROG, OP_ERASE
    } array_op_e;

    typedef struct packed {
        logic       is_cmd;
        logic       is_adr;
        logic       is_dat;
        logic [7:0] val;
    } bus_cycle_t;

    localparam logic [7:0] OPC_READ_SETUP  = 8'h00;
    localparam logic [7:0] OPC_READ_GO     = 8'h30;
    localparam logic [7:0] OPC_CB_GO       = 8'h35;
    localparam logic [7:0] OPC_PROG_SETUP  = 8'h80;
    localparam logic [7:0] OPC_PROG_GO     = 8'h10;
    localparam logic [7:0] OPC_RAND_IN     = 8'h85;
    localparam logic [7:0] OPC_RAND_OUT    = 8'h05;
    localparam logic [7:0] OPC_RAND_OUT_GO = 8'hE0;
    localparam logic [7:0] OPC_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OPC_STATUS      = 8'h70;
    localparam logic [7:0] OPC_RESET       = 8'hFF;

    function automatic logic [7:0] status_byte(input logic ready, input logic fail);
        return {1'b0, ready, 5'b00000, fail};
    endfunction

endpackage

// File: rtl/nand_strobe_cap.sv
module nand_strobe_cap
    import nand_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] din,
    output bus_cycle_t cyc,
    output logic       rd_adv
);
    logic we_q, re_q, we_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    assign we_rise = !we_q && we_n && !ce_n;

    always_comb begin
        cyc.is_cmd = we_rise && cle && !ale;
        cyc.is_adr = we_rise && ale && !cle;
        cyc.is_dat = we_rise && !ale && !cle;
        cyc.val    = din;
    end

    assign rd_adv = !re_q && re_n && !ce_n;

    // R1: a captured cycle needs the previous strobe sample low
    assert_capture_edge_R1: assert property (@(posedge clk) disable iff (rst)
        (cyc.is_cmd || cyc.is_adr || cyc.is_dat) |=> !$past(we_q));

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          clr,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)        cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == TW'(1)) && !clr;

    // R10: a running interval counts down by one each cycle
    assert_count_down_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !clr && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nand_page_store.sv
module nand_page_store #(
    parameter int COL_BITS    = 4,
    parameter int PAGE_BITS   = 3,
    parameter int BLK_PG_BITS = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 buf_fill,
    input  logic                 buf_wr,
    input  logic [COL_BITS-1:0]  wr_col,
    input  logic [7:0]           wr_byte,
    input  logic                 buf_load,
    input  logic                 arr_prog,
    input  logic                 arr_erase,
    input  logic [PAGE_BITS-1:0] page_idx,
    input  logic [COL_BITS-1:0]  rd_col,
    output logic [7:0]           rd_byte
);
    localparam int BYTES = 1 << COL_BITS;
    localparam int PAGES = 1 << PAGE_BITS;

    logic [7:0] arr  [PAGES][BYTES];
    logic [7:0] pbuf [BYTES];

    function automatic logic [PAGE_BITS-1:0] blk_of(input logic [PAGE_BITS-1:0] p);
        return p >> BLK_PG_BITS;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < BYTES; b++) pbuf[b] <= 8'hFF;
        end else if (buf_fill) begin
            for (int b = 0; b < BYTES; b++) pbuf[b] <= 8'hFF;
        end else if (buf_wr) begin
            pbuf[wr_col] <= wr_byte;
        end else if (buf_load) begin
            for (int b = 0; b < BYTES; b++) pbuf[b] <= arr[page_idx][b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < PAGES; p++)
                for (int b = 0; b < BYTES; b++) arr[p][b] <= 8'hFF;
        end else if (arr_prog) begin
            for (int b = 0; b < BYTES; b++) arr[page_idx][b] <= pbuf[b];
        end else if (arr_erase) begin
            for (int p = 0; p < PAGES; p++)
                if (blk_of(PAGE_BITS'(p)) == blk_of(page_idx))
                    for (int b = 0; b < BYTES; b++) arr[p][b] <= 8'hFF;
        end
    end

    assign rd_byte = pbuf[rd_col];

    // R8: program and erase never commit in the same cycle
    assert_single_commit_R8: assert property (@(posedge clk) disable iff (rst)
        !(arr_prog && arr_erase));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_BITS    = 4,
    parameter int PAGE_BITS   = 3,
    parameter int BLK_PG_BITS = 1,
    parameter int READ_CYC    = 12,
    parameter int PROG_CYC    = 40,
    parameter int ERASE_CYC   = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       rb
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ?
                          ((ERASE_CYC > READ_CYC) ? ERASE_CYC : READ_CYC) :
                          ((PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC);
    localparam int TW    = $clog2(MAXC + 1);
    localparam int ROW_W = 24;

    bus_cycle_t          cyc;
    logic                rd_adv;
    seq_state_e          state;
    array_op_e           op;
    logic [2:0]          adr_cnt;
    logic [COL_BITS-1:0] col;
    logic [ROW_W-1:0]    row;
    logic                data_seen, stat_mode, fail;
    logic                timer_done, timer_load, busy, rst_cmd, oor;
    logic                go_read, go_cb, go_prog, go_erase;
    logic [TW-1:0]       load_val;
    logic                buf_fill, buf_wr, buf_load, arr_prog, arr_erase;
    logic [7:0]          rd_byte;

    nand_strobe_cap u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .din(din), .cyc(cyc), .rd_adv(rd_adv)
    );

    assign busy    = (state == S_BUSY);
    assign rst_cmd = cyc.is_cmd && (cyc.val == OPC_RESET);
    assign oor     = |row[ROW_W-1:PAGE_BITS];

    always_comb begin
        go_read  = cyc.is_cmd && state == S_RD_CONF && cyc.val == OPC_READ_GO;
        go_cb    = cyc.is_cmd && state == S_RD_CONF && cyc.val == OPC_CB_GO;
        go_prog  = cyc.is_cmd && state == S_PG_DATA && data_seen && cyc.val == OPC_PROG_GO;
        go_erase = cyc.is_cmd && state == S_ER_CONF && cyc.val == OPC_ERASE_GO;
        timer_load = go_read || go_cb || go_prog || go_erase;
        if (go_prog)       load_val = TW'(PROG_CYC);
        else if (go_erase) load_val = TW'(ERASE_CYC);
        else               load_val = TW'(READ_CYC);
    end

    nand_busy_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(timer_load), .load_val(load_val),
        .clr(rst_cmd), .done(timer_done)
    );

    always_comb begin
        buf_fill  = cyc.is_cmd && !busy && cyc.val == OPC_PROG_SETUP;
        buf_wr    = cyc.is_dat && state == S_PG_DATA;
        buf_load  = timer_done && busy && (op == OP_READ || op == OP_CBREAD);
        arr_prog  = timer_done && busy && op == OP_PROG && !oor;
        arr_erase = timer_done && busy && op == OP_ERASE && !oor;
    end

    nand_page_store #(
        .COL_BITS(COL_BITS), .PAGE_BITS(PAGE_BITS), .BLK_PG_BITS(BLK_PG_BITS)
    ) u_store (
        .clk(clk), .rst(rst), .buf_fill(buf_fill), .buf_wr(buf_wr),
        .wr_col(col), .wr_byte(cyc.val), .buf_load(buf_load),
        .arr_prog(arr_prog), .arr_erase(arr_erase),
        .page_idx(row[PAGE_BITS-1:0]), .rd_col(col), .rd_byte(rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            op        <= OP_READ;
            adr_cnt   <= '0;
            col       <= '0;
            row       <= '0;
            data_seen <= 1'b0;
            stat_mode <= 1'b0;
            fail      <= 1'b0;
        end else if (rst_cmd) begin
            state     <= S_IDLE;
            adr_cnt   <= '0;
            data_seen <= 1'b0;
            stat_mode <= 1'b0;
            fail      <= 1'b0;
        end else begin
            if (timer_done && busy) begin
                unique case (op)
                    OP_READ:   state <= S_RD_OUT;
                    OP_CBREAD: state <= S_CB_HOLD;
                    default: begin
                        state <= S_IDLE;
                        fail  <= oor;
                    end
                endcase
            end
            if (cyc.is_cmd) begin
                if (cyc.val == OPC_STATUS) begin
                    stat_mode <= 1'b1;
                end else if (!busy) begin
                    stat_mode <= 1'b0;
                    adr_cnt   <= '0;
                    unique case (cyc.val)
                        OPC_READ_SETUP: state <= S_RD_ADR;
                        OPC_PROG_SETUP: begin
                            state     <= S_PG_ADR;
                            data_seen <= 1'b0;
                        end
                        OPC_ERASE_SETUP: state <= S_ER_ADR;
                        OPC_READ_GO, OPC_CB_GO: begin
                            state <= (state == S_RD_CONF) ? S_BUSY : S_IDLE;
                            op    <= (cyc.val == OPC_CB_GO) ? OP_CBREAD : OP_READ;
                        end
                        OPC_RAND_IN: begin
                            if (state == S_PG_DATA) state <= S_RIN_ADR;
                            else if (state == S_CB_HOLD) begin
                                state     <= S_PG_ADR;
                                data_seen <= 1'b1;
                            end else state <= S_IDLE;
                        end
                        OPC_PROG_GO: begin
                            state <= go_prog ? S_BUSY : S_IDLE;
                            op    <= OP_PROG;
                        end
                        OPC_ERASE_GO: begin
                            state <= go_erase ? S_BUSY : S_IDLE;
                            op    <= OP_ERASE;
                        end
                        OPC_RAND_OUT:
                            state <= (state == S_RD_OUT) ? S_ROUT_ADR : S_IDLE;
                        OPC_RAND_OUT_GO:
                            state <= (state == S_ROUT_CONF) ? S_RD_OUT : S_IDLE;
                        default: state <= S_IDLE;
                    endcase
                end
            end else if (cyc.is_adr) begin
                adr_cnt <= adr_cnt + 1'b1;
                unique case (state)
                    S_RD_ADR, S_PG_ADR: begin
                        unique case (adr_cnt)
                            3'd0: col <= COL_BITS'({8'h00, cyc.val});
                            3'd1: col <= col | COL_BITS'({cyc.val, 8'h00});
                            3'd2: row[7:0]   <= cyc.val;
                            3'd3: row[15:8]  <= cyc.val;
                            default: begin
                                row[23:16] <= cyc.val;
                                state <= (state == S_RD_ADR) ? S_RD_CONF : S_PG_DATA;
                            end
                        endcase
                    end
                    S_ER_ADR: begin
                        unique case (adr_cnt)
                            3'd0: row[7:0]  <= cyc.val;
                            3'd1: row[15:8] <= cyc.val;
                            default: begin
                                row[23:16] <= cyc.val;
                                state <= S_ER_CONF;
                            end
                        endcase
                    end
                    S_RIN_ADR, S_ROUT_ADR: begin
                        if (adr_cnt == 3'd0) col <= COL_BITS'({8'h00, cyc.val});
                        else begin
                            col   <= col | COL_BITS'({cyc.val, 8'h00});
                            state <= (state == S_RIN_ADR) ? S_PG_DATA : S_ROUT_CONF;
                        end
                    end
                    default: ;
                endcase
            end else if (buf_wr) begin
                col       <= col + 1'b1;
                data_seen <= 1'b1;
            end
            if (rd_adv && state == S_RD_OUT && !stat_mode) col <= col + 1'b1;
        end
    end

    assign rb   = !busy;
    assign dout = stat_mode ? status_byte(rb, fail) : rd_byte;

    // R10: busy persists until the interval ends or a reset command arrives
    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !timer_done && !rst_cmd) |=> !rb);

    // R5: a program confirm outside data entry leaves the block ready
    assert_stray_confirm_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && cyc.is_cmd && cyc.val == OPC_PROG_GO && state != S_PG_DATA) |=> rb);

    // R3: a read confirm while addresses are still expected starts nothing
    assert_short_address_R3: assert property (@(posedge clk) disable iff (rst)
        (cyc.is_cmd && cyc.val == OPC_READ_GO && state == S_RD_ADR) |=> rb);

    // R12: reset command always leaves the block ready
    assert_reset_ready_R12: assert property (@(posedge clk) disable iff (rst)
        rst_cmd |=> (rb && !fail));

    // R11: the ready bit of the status byte follows the ready/busy pin
    assert_status_ready_R11: assert property (@(posedge clk) disable iff (rst)
        stat_mode |-> (dout[6] == rb));

endmodule

// File: tb/nand_cmd_seq_tb_top.sv
module nand_cmd_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       rb;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    nand_cmd_seq dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .din(din), .dout(dout), .rb(rb)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] v, input logic ce);
        @(negedge clk);
        ce_n = ce; cle = c; ale = a; din = v; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] v);  wr(1'b1, 1'b0, v, 1'b0); endtask
    task automatic adr(input logic [7:0] v);  wr(1'b0, 1'b1, v, 1'b0); endtask
    task automatic dat(input logic [7:0] v);  wr(1'b0, 1'b0, v, 1'b0); endtask

    task automatic addr5(input logic [15:0] c, input logic [23:0] r);
        adr(c[7:0]); adr(c[15:8]); adr(r[7:0]); adr(r[15:8]); adr(r[23:16]);
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!rb && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!rb) chk(req, 8'(rb), 8'h01);
    endtask

    task automatic rd_byte(output logic [7:0] x);
        x = dout;
        re_n = 1'b0;
        @(negedge clk);
        re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic open_page(input logic [15:0] c, input logic [23:0] r);
        cmd(8'h00); addr5(c, r); cmd(8'h30);
        wait_ready("R2 read busy");
    endtask

    task automatic t_reset;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 rb after reset", 8'(rb), 8'h01);
        cmd(8'h70);
        chk("R11 status after reset", dout, 8'h40);
    endtask

    task automatic t_program_read;
        logic [7:0] x;
        cmd(8'h80); addr5(16'd3, 24'd2);
        dat(8'hA1); dat(8'hB2); dat(8'hC3);
        cmd(8'h10);
        chk("R10 rb low after confirm", 8'(rb), 8'h00);
        wait_ready("R4 program busy");
        open_page(16'd0, 24'd2);
        rd_byte(x); chk("R4 unwritten col0", x, 8'hFF);
        rd_byte(x); rd_byte(x);
        rd_byte(x); chk("R2 col3", x, 8'hA1);
        rd_byte(x); chk("R2 col4 advance", x, 8'hB2);
        rd_byte(x); chk("R4 col5", x, 8'hC3);
        rd_byte(x); chk("R4 col6 unwritten", x, 8'hFF);
    endtask

    task automatic t_short_addr;
        cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h02); adr(8'h00);
        cmd(8'h30);
        chk("R3 four address cycles no busy", 8'(rb), 8'h01);
    endtask

    task automatic t_stray_confirm;
        logic [7:0] x;
        dat(8'h99); cmd(8'h10);
        chk("R5 lone confirm", 8'(rb), 8'h01);
        cmd(8'h80); addr5(16'd0, 24'd5); cmd(8'h10);
        chk("R5 confirm without data", 8'(rb), 8'h01);
        open_page(16'd0, 24'd5);
        rd_byte(x); chk("R5 page untouched", x, 8'hFF);
    endtask

    task automatic t_rand_in;
        cmd(8'h80); addr5(16'd0, 24'd4);
        dat(8'h11); dat(8'h22);
        cmd(8'h85); adr(8'd8); adr(8'd0); dat(8'h33);
        cmd(8'h85); adr(8'd1); adr(8'd0); dat(8'h44);
        cmd(8'h10);
        wait_ready("R6 program busy");
    endtask

    task automatic t_rand_out;
        logic [7:0] x;
        open_page(16'd0, 24'd4);
        rd_byte(x); chk("R6 col0", x, 8'h11);
        cmd(8'h05); adr(8'd8); adr(8'd0); cmd(8'hE0);
        rd_byte(x); chk("R7 relocate to col8", x, 8'h33);
        cmd(8'h05); adr(8'd1); adr(8'd0); cmd(8'hE0);
        rd_byte(x); chk("R6 overwritten col1", x, 8'h44);
        rd_byte(x); chk("R7 advance after relocate", x, 8'hFF);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] x;
        logic       mism = 1'b0;
        cmd(8'h80); addr5(16'd0, 24'd6); dat(8'h5A); cmd(8'h10);
        cmd(8'h00); cmd(8'h60);
        chk("R10 commands ignored while busy", 8'(rb), 8'h00);
        ce_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 ce high while busy", 8'(rb), 8'h00);
        ce_n = 1'b0;
        cmd(8'h70);
        chk("R11 status while busy", dout, 8'h00);
        for (int i = 0; i < 200 && !rb; i++) begin
            if (dout[6] !== rb) mism = 1'b1;
            @(negedge clk);
        end
        if (dout[6] !== rb) mism = 1'b1;
        chk("R11 ready bit tracks rb", 8'(mism), 8'h00);
        chk("R11 status after done", dout, 8'h40);
        open_page(16'd0, 24'd6);
        rd_byte(x); chk("R10 program completed", x, 8'h5A);
    endtask

    task automatic t_copyback;
        logic [7:0] x;
        cmd(8'h00); addr5(16'd0, 24'd4); cmd(8'h35);
        chk("R9 copy read busy", 8'(rb), 8'h00);
        wait_ready("R9 copy read");
        cmd(8'h85); addr5(16'd0, 24'd7); dat(8'h77); cmd(8'h10);
        chk("R9 copy program busy", 8'(rb), 8'h00);
        wait_ready("R9 copy program");
        open_page(16'd0, 24'd7);
        rd_byte(x); chk("R9 modified byte", x, 8'h77);
        rd_byte(x); chk("R9 copied col1", x, 8'h44);
        cmd(8'h05); adr(8'd8); adr(8'd0); cmd(8'hE0);
        rd_byte(x); chk("R9 copied col8", x, 8'h33);
    endtask

    task automatic t_erase;
        logic [7:0] x;
        cmd(8'h80); addr5(16'd0, 24'd3); dat(8'h3C); cmd(8'h10);
        wait_ready("R8 program page3");
        cmd(8'h60); adr(8'd3); adr(8'd0); adr(8'd0); cmd(8'hD0);
        chk("R8 erase busy", 8'(rb), 8'h00);
        wait_ready("R8 erase");
        open_page(16'd3, 24'd2);
        rd_byte(x); chk("R8 page2 erased", x, 8'hFF);
        open_page(16'd0, 24'd3);
        rd_byte(x); chk("R8 page3 erased", x, 8'hFF);
        open_page(16'd0, 24'd4);
        rd_byte(x); chk("R8 other block kept", x, 8'h11);
    endtask

    task automatic t_fail_status;
        logic [7:0] x;
        cmd(8'h80); addr5(16'd0, 24'h000100); dat(8'h01); cmd(8'h10);
        wait_ready("R11 bad program");
        cmd(8'h70);
        chk("R11 fail bit", dout, 8'h41);
        open_page(16'd0, 24'd0);
        rd_byte(x); chk("R11 array unchanged", x, 8'hFF);
        cmd(8'hFF);
        cmd(8'h70);
        chk("R12 reset clears fail", dout, 8'h40);
    endtask

    task automatic t_reset_abort;
        logic [7:0] x;
        cmd(8'h80); addr5(16'd0, 24'd1); dat(8'h12); cmd(8'h10);
        cmd(8'hFF);
        chk("R12 rb high after abort", 8'(rb), 8'h01);
        cmd(8'h80); addr5(16'd0, 24'd1); dat(8'h99); cmd(8'hFF); cmd(8'h10);
        chk("R12 unconfirmed sequence dropped", 8'(rb), 8'h01);
        open_page(16'd0, 24'd1);
        rd_byte(x); chk("R12 page left erased", x, 8'hFF);
    endtask

    task automatic t_chip_enable;
        logic [7:0] x;
        cmd(8'h80); addr5(16'd0, 24'd5); dat(8'h55);
        wr(1'b1, 1'b0, 8'h10, 1'b1);
        chk("R1 strobe ignored with ce high", 8'(rb), 8'h01);
        cmd(8'h10);
        chk("R1 strobe taken with ce low", 8'(rb), 8'h00);
        wait_ready("R1 program");
        open_page(16'd0, 24'd5);
        rd_byte(x); chk("R1 data byte", x, 8'h55);
    endtask

    initial begin
        t_reset();
        t_program_read();
        t_short_addr();
        t_stray_confirm();
        t_rand_in();
        t_rand_out();
        t_busy_ignore();
        t_copyback();
        t_erase();
        t_fail_status();
        t_reset_abort();
        t_chip_enable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule